// File: doc/BRIEF.md
# Fly-by Block Transfer Engine

This block is a single-channel DMA engine for peripheral-to-memory block moves in which the engine never carries the data. Software programs a destination address and a byte count through a small register port, then issues a start command. The engine waits until the peripheral reports that its internal buffer holds valid data. It then places the destination address on the shared bus and raises a read request. The peripheral writes the next 4-byte word straight to memory at that address and answers with an acknowledge.

Each acknowledge moves the engine forward by one word: the address grows by 4 and the remaining count shrinks by 4. When the count reaches zero, the engine drops its busy flag, sets a done flag and holds a level interrupt until software clears it.

The request/acknowledge pair works as a valid/ready handshake with back-pressure from the peripheral:
- The request is the valid side. Once raised, it stays high and the address stays fixed for as many cycles as the peripheral needs before it acknowledges.
- A word counts as transferred only in a cycle where the request and the acknowledge are both high.
- An acknowledge that arrives while no request is raised is ignored.
- After each acknowledge, the request is low for at least one cycle.

Top module: `flyby_dma`

## Requirements
- R1: After reset, the busy flag, done flag, interrupt and read request are low, and the readback of the address and count registers is zero.
- R2: While idle, a write to select 0 loads the destination address and a write to select 1 loads the byte count. Reading the same select returns the live address or remaining count.
- R3: A write to select 2 with bit 0 set starts the channel (status bit 0 busy goes high) only if the count is a nonzero multiple of 4. A start with a count that is not a multiple of 4 changes nothing.
- R4: While busy, the read request is raised only after a cycle in which the peripheral's ready input was high. While ready is low, no request is issued.
- R5: While a request waits for an acknowledge, the request stays high and the bus address stays unchanged. The bus address equals the current destination address.
- R6: Each acknowledged request adds 4 to the address and subtracts 4 from the count, so the words go to dest, dest+4, dest+8 and so on.
- R7: In the cycle after an acknowledge, the request is low.
- R8: The acknowledge of the last word clears busy and sets status bit 1 (done) and the interrupt, all at the same clock edge.
- R9: A start with a zero count sets done and the interrupt at the next edge and never raises a request.
- R10: The interrupt follows the done flag. Writing select 3 with bit 1 set clears done while idle; writing select 3 with bit 1 clear leaves it set.
- R11: While busy, all register writes are ignored, including new address, count and start writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 status |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Readback of the selected register (combinational) |
| per_ready | input | 1 | Peripheral buffer holds valid data |
| bus_addr | output | 32 | Destination memory address driven on the bus |
| bus_rd_req | output | 1 | Read request to the peripheral (valid side) |
| bus_ack | input | 1 | Peripheral acknowledge, word written to memory |
| irq | output | 1 | Level completion interrupt |

## Verification
The assertions check the handshake rules on every cycle:
- the request is held, and the address kept stable, until the acknowledge;
- the request drops after each acknowledge;
- a request is raised only after ready was seen;
- each acknowledge steps the address;
- the completion edge clears busy and raises the interrupt;
- a count write while busy leaves the count unchanged;
- the interrupt falls only on a clear-done write.

Only the bench scenarios can show the rest. These are the full address sequence and word count for blocks of different sizes and acknowledge latencies, address wrap-around, and that misaligned and zero-count starts are handled correctly. They also include whether writes made during a transfer alter its final result.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_REQ} fbd_state_e;

  localparam logic [1:0] SEL_DEST = 2'd0;
  localparam logic [1:0] SEL_LEN  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam int CTRL_GO   = 0;
  localparam int STAT_BUSY = 0;
  localparam int STAT_DONE = 1;
endpackage

// File: rtl/fbd_progress.sv
module fbd_progress #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_dest,
  input  logic          ld_len,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_len,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] remain,
  output logic          last
);
  localparam logic [AW-1:0] ADDR_INC = AW'(WORD_BYTES);
  localparam logic [CW-1:0] CNT_DEC  = CW'(WORD_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
    end else if (ld_dest) begin
      cur_addr <= wr_addr;
    end else if (step) begin
      cur_addr <= cur_addr + ADDR_INC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (ld_len) begin
      remain <= wr_len;
    end else if (step) begin
      remain <= remain - CNT_DEC;
    end
  end

  assign last = (remain == CNT_DEC);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> remain >= CNT_DEC) else $error("count underflow"); // R6
endmodule

// File: rtl/fbd_seq.sv
module fbd_seq
  import fbd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_run,
  input  logic per_ready,
  input  logic bus_ack,
  input  logic last,
  output logic busy,
  output logic bus_rd_req,
  output logic step,
  output logic finish
);
  fbd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (go_run) state_d = ST_WAIT;
      ST_WAIT: if (per_ready) state_d = ST_REQ;
      ST_REQ:  if (bus_ack) state_d = last ? ST_IDLE : ST_WAIT;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy       = (state_q != ST_IDLE);
  assign bus_rd_req = (state_q == ST_REQ);
  assign step       = bus_rd_req && bus_ack;
  assign finish     = step && last;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_req && !bus_ack |=> bus_rd_req) else $error("request dropped"); // R5
  AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_req && bus_ack |=> !bus_rd_req) else $error("no gap"); // R7
  AST_REQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_req) |-> $past(per_ready)) else $error("req without ready"); // R4
endmodule

// File: rtl/fbd_regs.sv
module fbd_regs
  import fbd_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic          go_bit,
  input  logic          clr_bit,
  input  logic          busy,
  input  logic          finish,
  input  logic [AW-1:0] cur_addr,
  input  logic [CW-1:0] remain,
  output logic          ld_dest,
  output logic          ld_len,
  output logic          go_run,
  output logic          done,
  output logic [DW-1:0] cfg_rdata
);
  localparam int LSB = $clog2(WORD_BYTES);

  logic wr_idle, go_req, len_zero, len_aligned, go_zero, clr_done;

  assign wr_idle  = cfg_we && !busy;
  assign ld_dest  = wr_idle && (cfg_sel == SEL_DEST);
  assign ld_len   = wr_idle && (cfg_sel == SEL_LEN);
  assign go_req   = wr_idle && (cfg_sel == SEL_CTRL) && go_bit;
  assign clr_done = wr_idle && (cfg_sel == SEL_STAT) && clr_bit;
  assign len_zero = (remain == '0);

  generate
    if (LSB == 0) begin : g_any_len
      assign len_aligned = 1'b1;
    end else begin : g_word_len
      assign len_aligned = (remain[LSB-1:0] == '0);
    end
  endgenerate

  assign go_run  = go_req && !len_zero && len_aligned;
  assign go_zero = go_req && len_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  done <= 1'b0;
    else if (go_run)             done <= 1'b0;
    else if (finish || go_zero)  done <= 1'b1;
    else if (clr_done)           done <= 1'b0;
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_sel)
      SEL_DEST: cfg_rdata = DW'(cur_addr);
      SEL_LEN:  cfg_rdata = DW'(remain);
      SEL_STAT: begin
        cfg_rdata[STAT_BUSY] = busy;
        cfg_rdata[STAT_DONE] = done;
      end
      default:  cfg_rdata = '0;
    endcase
  end

  AST_BAD_LEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    go_req && !len_aligned |=> !busy && done == $past(done)) else $error("misaligned start"); // R3
  AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    go_zero |=> done && !busy) else $error("zero start"); // R9
endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
  import fbd_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          per_ready,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd_req,
  input  logic          bus_ack,
  output logic          irq
);
  logic          ld_dest, ld_len, go_run, done, busy, step, finish, last;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] remain;

  fbd_regs #(.AW(AW), .CW(CW), .DW(DW), .WORD_BYTES(WORD_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .go_bit(cfg_wdata[CTRL_GO]), .clr_bit(cfg_wdata[STAT_DONE]),
    .busy(busy), .finish(finish), .cur_addr(cur_addr), .remain(remain),
    .ld_dest(ld_dest), .ld_len(ld_len), .go_run(go_run), .done(done),
    .cfg_rdata(cfg_rdata)
  );

  fbd_progress #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_progress (
    .clk(clk), .rst_n(rst_n), .ld_dest(ld_dest), .ld_len(ld_len),
    .wr_addr(cfg_wdata[AW-1:0]), .wr_len(cfg_wdata[CW-1:0]), .step(step),
    .cur_addr(cur_addr), .remain(remain), .last(last)
  );

  fbd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go_run(go_run), .per_ready(per_ready),
    .bus_ack(bus_ack), .last(last), .busy(busy), .bus_rd_req(bus_rd_req),
    .step(step), .finish(finish)
  );

  assign bus_addr = cur_addr;
  assign irq      = done;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_req && !bus_ack |=> $stable(bus_addr)) else $error("addr moved"); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_req && bus_ack |=> bus_addr == $past(bus_addr) + AW'(WORD_BYTES)) else $error("addr step"); // R6
  AST_LAST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_req && bus_ack && remain == CW'(WORD_BYTES) |=> !busy && irq) else $error("finish"); // R8
  AST_BUSY_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cfg_we && cfg_sel == SEL_LEN && !(bus_rd_req && bus_ack) |=> remain == $past(remain))
    else $error("busy write took effect"); // R11
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(cfg_we && cfg_sel == SEL_STAT && cfg_wdata[STAT_DONE]) || $past(go_run))
    else $error("irq fell"); // R10
endmodule

// File: tb/test_flyby_dma.sv
module test_flyby_dma;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        per_ready = 1'b1;
  logic [31:0] bus_addr;
  logic        bus_rd_req;
  logic        bus_ack = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int ack_cnt = 0;
  int exp_words = 0;
  int lat = 0;
  int wait_n = 0;
  logic [31:0] exp_addr = '0;
  logic req_seen = 1'b0;
  logic ended = 1'b0;

  typedef struct packed {
    logic [31:0] dest;
    logic [15:0] len;
    logic [3:0]  lat;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'h0000_1000, 16'd4,  4'd0},
    '{32'h2000_0040, 16'd16, 4'd1},
    '{32'h0000_FFF0, 16'd32, 4'd3},
    '{32'hFFFF_FFF8, 16'd12, 4'd0},
    '{32'h0000_0100, 16'd64, 4'd2}
  };

  flyby_dma i_flyby_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .per_ready(per_ready),
    .bus_addr(bus_addr), .bus_rd_req(bus_rd_req), .bus_ack(bus_ack), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] sel, output logic [31:0] data);
    cfg_sel = sel;
    #1;
    data = cfg_rdata;
  endtask

  task automatic wait_irq(input int max);
    for (int n = 0; n < max && !irq; n++) @(negedge clk);
  endtask

  // Peripheral model: acknowledges after lat waiting cycles, checks the handshake.
  initial begin
    forever begin
      @(negedge clk);
      if (bus_rd_req) req_seen = 1'b1;
      if (bus_ack) begin
        bus_ack = 1'b0;
        check("R7 request low after ack", {31'd0, bus_rd_req}, 32'd0);
        if (ack_cnt == exp_words)
          check("R8 irq with last ack", {31'd0, irq}, 32'd1);
      end else if (bus_rd_req) begin
        check("R5 address held and correct", bus_addr, exp_addr);
        if (wait_n >= lat) begin
          bus_ack = 1'b1;
          exp_addr = exp_addr + 32'd4;
          ack_cnt++;
          wait_n = 0;
        end else begin
          wait_n++;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cfg_read(2'd0, rd); check("R1 address reset", rd, 32'd0);
    cfg_read(2'd1, rd); check("R1 count reset", rd, 32'd0);
    cfg_read(2'd3, rd); check("R1 status reset", rd, 32'd0);
    check("R1 irq/req reset", {30'd0, irq, bus_rd_req}, 32'd0);

    // R2 readback
    cfg_write(2'd0, 32'hABCD_0010);
    cfg_read(2'd0, rd); check("R2 address readback", rd, 32'hABCD_0010);
    cfg_write(2'd1, 32'd20);
    cfg_read(2'd1, rd); check("R2 count readback", rd, 32'd20);

    // R3 misaligned count rejected
    cfg_write(2'd1, 32'd6);
    cfg_write(2'd2, 32'd1);
    repeat (3) @(negedge clk);
    cfg_read(2'd3, rd); check("R3 misaligned start ignored", rd, 32'd0);
    check("R3 no request", {31'd0, bus_rd_req}, 32'd0);

    // R9 zero count, R10 clear
    req_seen = 1'b0;
    cfg_write(2'd1, 32'd0);
    cfg_write(2'd2, 32'd1);
    cfg_read(2'd3, rd); check("R9 zero start done", rd, 32'd2);
    check("R9 irq raised", {31'd0, irq}, 32'd1);
    repeat (4) @(negedge clk);
    check("R9 no request issued", {31'd0, req_seen}, 32'd0);
    cfg_write(2'd3, 32'd0);
    check("R10 write 0 keeps irq", {31'd0, irq}, 32'd1);
    cfg_write(2'd3, 32'd2);
    check("R10 write 1 clears irq", {31'd0, irq}, 32'd0);

    // Vector table: main transfer under several sizes and latencies
    foreach (VECS[i]) begin
      exp_addr = VECS[i].dest;
      exp_words = int'(VECS[i].len) / 4;
      ack_cnt = 0;
      lat = int'(VECS[i].lat);
      cfg_write(2'd0, VECS[i].dest);
      cfg_write(2'd1, {16'd0, VECS[i].len});
      cfg_write(2'd2, 32'd1);
      wait_irq(2000);
      @(negedge clk);
      check("R6 word count", ack_cnt, exp_words);
      cfg_read(2'd0, rd); check("R6 final address", rd, VECS[i].dest + {16'd0, VECS[i].len});
      cfg_read(2'd1, rd); check("R6 final count", rd, 32'd0);
      cfg_read(2'd3, rd); check("R8 done not busy", rd, 32'd2);
      cfg_write(2'd3, 32'd2);
      check("R10 cleared after block", {31'd0, irq}, 32'd0);
    end

    // R4 no request without ready; R11 writes while busy ignored
    per_ready = 1'b0;
    lat = 0; ack_cnt = 0; exp_words = 2; exp_addr = 32'h0000_0300;
    cfg_write(2'd0, 32'h0000_0300);
    cfg_write(2'd1, 32'd8);
    req_seen = 1'b0;
    cfg_write(2'd2, 32'd1);
    repeat (8) @(negedge clk);
    check("R4 no request while not ready", {31'd0, req_seen}, 32'd0);
    cfg_read(2'd3, rd); check("R3 busy after start", rd, 32'd1);
    cfg_write(2'd0, 32'h0000_0999);
    cfg_write(2'd1, 32'd100);
    cfg_write(2'd3, 32'd2);
    cfg_read(2'd0, rd); check("R11 address write ignored", rd, 32'h0000_0300);
    cfg_read(2'd1, rd); check("R11 count write ignored", rd, 32'd8);
    per_ready = 1'b1;
    wait_irq(200);
    @(negedge clk);
    cfg_read(2'd0, rd); check("R11 final address unaffected", rd, 32'h0000_0308);
    check("R4 words after ready", ack_cnt, 2);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule